// File: doc/BRIEF.md
# Resynchronizing Bit-Period Timer

This block times the bit cells of an oversampled serial receiver. A counter runs through one bit period of internal clock cycles and wraps, and a one-cycle sample event is raised whenever the counter stands at a chosen offset. A receive controller uses the event as its strobe for latching a data bit.

The counter can be steered from outside. A synchronous restart pulls it back to zero, so a controller that restarts it on every line edge keeps the sample point a fixed distance after that edge. A jump-forward control loads the counter straight to the sample position, so the event comes on the next cycle. While idle, a controller holds the timer in restart. After a frame, it restarts the timer and waits for an event to time a guard gap between frames.

The period parameter must be above 2 and the offset below the period parameter minus 2. With the defaults (period parameter 7, offset 2), one bit lasts eight clocks.

Top module: `bit_period_timer`

## Requirements
- R1: While `rst` is high at a rising clock edge, the counter is cleared and `evt_reg` goes low. With the default offset of 2, `evt_now` is also low after that edge. Once `rst` is released with `en` high, the first `evt_now` comes after OFFSET clock edges.
- R2: A low `restart_n` at an edge sets the counter to zero. It overrides `en` and `jump_n`. After releasing it with `en` high, `evt_now` rises after exactly OFFSET further edges, which is 1+OFFSET clocks after the restart cycle. A restart in mid-period realigns the event in the same way.
- R3: With `en` high and no restart or jump, `evt_now` is high for exactly one cycle in every RANGE+1 clocks. The counter runs 0..RANGE and then wraps to 0.
- R4: With `en` low and both controls idle (high), the counter holds its value. `evt_now` keeps its level, and the next event is delayed by the number of disabled cycles.
- R5: A low `jump_n` with `restart_n` high loads the counter with OFFSET, whatever the level of `en`. `evt_now` is high right after that edge. The next event then follows RANGE+1 enabled clocks later.
- R6: `evt_reg` equals the value `evt_now` had one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable |
| restart_n | input | 1 | Synchronous restart to zero, active low |
| jump_n | input | 1 | Load counter with the sample offset, active low |
| evt_now | output | 1 | Combinational sample event (counter equals offset) |
| evt_reg | output | 1 | Sample event registered by one clock |

## Verification
The hardest case to reach from the ports is a freeze that lands exactly on the sample cycle. Only there can a broken hold show up as a stretched or missing event. The bench gets there by restarting the timer and counting exactly OFFSET enabled edges. It then drops `en` while `evt_now` is high and checks that both outputs stay high for several cycles. A jump issued with `en` low, and a restart issued together with a jump, test the priority order among the three controls.

// File: rtl/bpt_pkg.sv
package bpt_pkg;

    // Action applied to the counter at the next clock edge
    typedef enum logic [1:0] {
        CMD_HOLD    = 2'd0,
        CMD_STEP    = 2'd1,
        CMD_RESTART = 2'd2,
        CMD_JUMP    = 2'd3
    } bpt_cmd_e;

    // Event pair carried from the decode stage to the outputs
    typedef struct packed {
        logic now;
        logic held;
    } bpt_evt_t;

    // Restart beats jump, jump beats enable
    function automatic bpt_cmd_e bpt_pick(input logic en,
                                          input logic restart_n,
                                          input logic jump_n);
        bpt_cmd_e c;
        if (!restart_n)
            c = CMD_RESTART;
        else if (!jump_n)
            c = CMD_JUMP;
        else if (en)
            c = CMD_STEP;
        else
            c = CMD_HOLD;
        return c;
    endfunction

endpackage

// File: rtl/bpt_cmd_decode.sv
module bpt_cmd_decode
    import bpt_pkg::*;
(
    input  logic     en,
    input  logic     restart_n,
    input  logic     jump_n,
    output bpt_cmd_e cmd
);

    always_comb begin
        cmd = bpt_pick(en, restart_n, jump_n);
    end

endmodule

// File: rtl/bpt_counter.sv
module bpt_counter
    import bpt_pkg::*;
#(
    parameter int RANGE  = 7,
    parameter int OFFSET = 2,
    parameter int CW     = $clog2(RANGE + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  bpt_cmd_e      cmd,
    output logic [CW-1:0] cnt
);

    localparam logic [CW-1:0] TOP_V  = CW'(RANGE);
    localparam logic [CW-1:0] LOAD_V = CW'(OFFSET);

    logic [CW-1:0] cnt_nx;

    always_comb begin
        unique case (cmd)
            CMD_RESTART: cnt_nx = '0;
            CMD_JUMP:    cnt_nx = LOAD_V;
            CMD_STEP:    cnt_nx = (cnt == TOP_V) ? '0 : cnt + CW'(1);
            default:     cnt_nx = cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else
            cnt <= cnt_nx;
    end

endmodule

// File: rtl/bpt_event.sv
module bpt_event
    import bpt_pkg::*;
#(
    parameter int OFFSET = 2,
    parameter int CW     = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cnt,
    output bpt_evt_t      evt
);

    localparam logic [CW-1:0] HIT_V = CW'(OFFSET);

    logic held_q;

    always_ff @(posedge clk) begin
        if (rst)
            held_q <= 1'b0;
        else
            held_q <= (cnt == HIT_V);
    end

    always_comb begin
        evt.now  = (cnt == HIT_V);
        evt.held = held_q;
    end

endmodule

// File: rtl/bit_period_timer.sv
module bit_period_timer
    import bpt_pkg::*;
#(
    parameter int RANGE  = 7,
    parameter int OFFSET = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic restart_n,
    input  logic jump_n,
    output logic evt_now,
    output logic evt_reg
);

    localparam int CW = $clog2(RANGE + 1);

    bpt_cmd_e      cmd;
    logic [CW-1:0] cnt;
    bpt_evt_t      evt;

    bpt_cmd_decode u_dec (
        .en        (en),
        .restart_n (restart_n),
        .jump_n    (jump_n),
        .cmd       (cmd)
    );

    bpt_counter #(
        .RANGE  (RANGE),
        .OFFSET (OFFSET),
        .CW     (CW)
    ) u_cnt (
        .clk (clk),
        .rst (rst),
        .cmd (cmd),
        .cnt (cnt)
    );

    bpt_event #(
        .OFFSET (OFFSET),
        .CW     (CW)
    ) u_evt (
        .clk (clk),
        .rst (rst),
        .cnt (cnt),
        .evt (evt)
    );

    assign evt_now = evt.now;
    assign evt_reg = evt.held;

endmodule

// File: rtl/bit_period_timer_chk.sv
module bit_period_timer_chk #(
    parameter int RANGE  = 7,
    parameter int OFFSET = 2
) (
    input logic clk,
    input logic rst,
    input logic en,
    input logic restart_n,
    input logic jump_n,
    input logic evt_now,
    input logic evt_reg
);

    localparam logic ZERO_HIT = (OFFSET == 0);

    logic armed;
    always_ff @(posedge clk) armed <= !rst;

    // R1
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> !evt_reg);

    // R2
    p_restart_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !restart_n |=> (evt_now == ZERO_HIT));

    // R3
    p_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        (evt_now && en && restart_n && jump_n) |=> !evt_now);

    // R4
    p_hold_level_r4: assert property (@(posedge clk) disable iff (rst)
        (!en && restart_n && jump_n) |=> $stable(evt_now));

    // R5
    p_jump_fires_r5: assert property (@(posedge clk) disable iff (rst)
        (restart_n && !jump_n) |=> evt_now);

    // R6
    p_delay_match_r6: assert property (@(posedge clk) disable iff (rst)
        armed |=> (evt_reg == $past(evt_now)));

endmodule

bind bit_period_timer bit_period_timer_chk #(
    .RANGE  (RANGE),
    .OFFSET (OFFSET)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .restart_n (restart_n),
    .jump_n    (jump_n),
    .evt_now   (evt_now),
    .evt_reg   (evt_reg)
);

// File: tb/sim_bit_period_timer.sv
module sim_bit_period_timer;

    localparam int CLK_P  = 10;
    localparam int RANGE  = 7;
    localparam int OFFSET = 2;
    localparam int PERIOD = RANGE + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0;
    logic restart_n = 1'b1;
    logic jump_n = 1'b1;
    logic evt_now;
    logic evt_reg;

    int total = 0;
    int bad = 0;

    always #(CLK_P/2) clk = ~clk;

    bit_period_timer #(.RANGE(RANGE), .OFFSET(OFFSET)) u0 (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .restart_n (restart_n),
        .jump_n    (jump_n),
        .evt_now   (evt_now),
        .evt_reg   (evt_reg)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Steps until evt_now is high, returning the step count
    task automatic wait_evt(input int lim, output int n);
        n = 0;
        while (!evt_now && n < lim) begin
            step();
            n++;
        end
    endtask

    task automatic do_restart();
        restart_n = 1'b0;
        step();
        restart_n = 1'b1;
    endtask

    task automatic t_reset();
        int n;
        rst = 1'b1; en = 1'b1; restart_n = 1'b1; jump_n = 1'b1;
        step();
        step();
        check("R1", "evt_now in reset", int'(evt_now), 0);
        check("R1", "evt_reg in reset", int'(evt_reg), 0);
        rst = 1'b0;
        wait_evt(4 * PERIOD, n);
        check("R1", "edges to first event after reset", n, OFFSET);
    endtask

    task automatic t_restart_timing();
        int n;
        en = 1'b1;
        do_restart();
        check("R2", "evt_now right after restart", int'(evt_now), 0);
        wait_evt(4 * PERIOD, n);
        check("R2", "edges from restart to event", n, OFFSET);
        check("R6", "evt_reg before delay", int'(evt_reg), 0);
        step();
        check("R6", "evt_reg one clock after event", int'(evt_reg), 1);
        check("R3", "evt_now one cycle wide", int'(evt_now), 0);
        step();
        check("R6", "evt_reg clears after event", int'(evt_reg), 0);
    endtask

    task automatic t_period();
        int n;
        en = 1'b1;
        do_restart();
        wait_evt(4 * PERIOD, n);
        for (int k = 0; k < 3; k++) begin
            step();
            check("R3", "event width", int'(evt_now), 0);
            wait_evt(4 * PERIOD, n);
            check("R3", "event spacing", n + 1, PERIOD);
        end
    endtask

    task automatic t_enable_hold();
        int n;
        en = 1'b1;
        do_restart();
        en = 1'b0;
        for (int k = 0; k < 5; k++) step();
        check("R4", "evt_now frozen low", int'(evt_now), 0);
        en = 1'b1;
        wait_evt(4 * PERIOD, n);
        check("R4", "edges to event after freeze", n, OFFSET);
        en = 1'b0;
        for (int k = 0; k < 3; k++) begin
            step();
            check("R4", "evt_now held high", int'(evt_now), 1);
        end
        check("R6", "evt_reg follows held event", int'(evt_reg), 1);
        en = 1'b1;
        step();
        check("R4", "event ends once enabled", int'(evt_now), 0);
        wait_evt(4 * PERIOD, n);
        check("R4", "spacing after frozen event", n + 1, PERIOD);
    endtask

    task automatic t_restart_priority();
        int n;
        en = 1'b1;
        jump_n = 1'b0;
        restart_n = 1'b0;
        step();
        jump_n = 1'b1;
        restart_n = 1'b1;
        check("R2", "restart wins over jump", int'(evt_now), 0);
        en = 1'b0;
        restart_n = 1'b0;
        step();
        step();
        restart_n = 1'b1;
        en = 1'b1;
        wait_evt(4 * PERIOD, n);
        check("R2", "restart with enable low", n, OFFSET);
    endtask

    task automatic t_restart_mid();
        int n;
        en = 1'b1;
        do_restart();
        wait_evt(4 * PERIOD, n);
        for (int k = 0; k < 4; k++) step();
        do_restart();
        wait_evt(4 * PERIOD, n);
        check("R2", "mid-period restart realigns", n, OFFSET);
    endtask

    task automatic t_jump();
        int n;
        en = 1'b1;
        do_restart();
        wait_evt(4 * PERIOD, n);
        for (int k = 0; k < 3; k++) step();
        check("R5", "no event before jump", int'(evt_now), 0);
        jump_n = 1'b0;
        step();
        jump_n = 1'b1;
        check("R5", "event right after jump", int'(evt_now), 1);
        step();
        wait_evt(4 * PERIOD, n);
        check("R5", "spacing after jump", n + 1, PERIOD);
        step();
        step();
        en = 1'b0;
        jump_n = 1'b0;
        step();
        jump_n = 1'b1;
        check("R5", "jump with enable low", int'(evt_now), 1);
        en = 1'b1;
    endtask

    initial begin
        #(CLK_P * 50000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_restart_timing();
        t_period();
        t_enable_hold();
        t_restart_priority();
        t_restart_mid();
        t_jump();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule